// File: doc/BRIEF.md
# Indexed Address Bus Cycle Sequencer

This block produces the bus cycles that an 8-bit processor issues for an absolute indexed memory access. It starts after the two operand bytes are known. A start strobe captures four things: a 16-bit base address, an 8-bit index, a store/read selector and a mode bit. The block also captures the program counter at the same moment. From the next clock onward it drives one bus cycle per clock. Each cycle has an address, a read/write flag, a flag that marks the extra page-crossing cycle, and a done flag on the last cycle.

The effective address is the base plus the index. The index is added to the low byte of the base. When that addition carries, the access has crossed a page boundary. An extra cycle is then inserted while the high byte is incremented, and the mode bit decides what address appears during that cycle:

- In legacy mode the bus shows the half-formed address: the correct low byte with the old high byte.
- In revised mode the bus shows the captured program counter, as a read.

A store reads the target before it writes it, except in one case. In revised mode, a store that crosses a page uses its program-counter read as the cycle before the write.

Top module: `idx_bus_sequencer`

## Requirements
- R1: After reset and while idle, addr_o is 0x0000, rnw_o is 1 (1 = read, 0 = write), dead_o is 0 and done_o is 0.
- R2: A read whose index added to the base low byte produces no carry takes exactly one cycle. That cycle starts the clock after start_i is sampled, is a read at base+index, and has done_o high.
- R3: A read whose low-byte sum carries takes two cycles: first a dead cycle, then a read at the full address. The full address has the summed low byte and the base high byte plus one, and done_o is high on the second cycle.
- R4: In legacy mode (legacy_i = 1) the dead cycle is a read at the partial address: the summed low byte with the unchanged base high byte.
- R5: In revised mode (legacy_i = 0) the dead cycle is a read at the pc_i value captured with start_i, and never at a partial address.
- R6: A store (store_i = 1) with no carry is a read at the full address followed by a write at the same address, in both modes.
- R7: A store with a carry in revised mode is a read at the captured program counter followed by a write at the full address.
- R8: A store with a carry in legacy mode is a read at the partial address, then a read at the full address, then a write at the full address.
- R9: dead_o is high only during the inserted page-crossing cycle. done_o is high for exactly one clock, on the final cycle of each sequence.
- R10: When the base high byte is 0xFF and the low-byte sum carries, the full address high byte wraps to 0x00.
- R11: start_i asserted while a sequence is in progress is ignored. The running sequence completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a sequence; sampled only when idle |
| base_i | input | 16 | Base address from the operand bytes |
| index_i | input | 8 | Index register value |
| store_i | input | 1 | 1 = store access, 0 = read access |
| legacy_i | input | 1 | 1 = legacy dead-cycle behaviour, 0 = revised |
| pc_i | input | 16 | Program counter, captured at start |
| addr_o | output | 16 | Address driven on the bus this cycle |
| rnw_o | output | 1 | 1 = read cycle, 0 = write cycle |
| dead_o | output | 1 | High during the inserted page-crossing cycle |
| done_o | output | 1 | High on the final cycle of a sequence |

## Verification
The hardest situation to reach is a legacy-mode store that crosses a page when the base high byte is 0xFF. That case needs all three cycles, and the partial address must keep 0xFF while the full address wraps to 0x00. The bench builds this from a base of 0xFF80 and an index of 0x90. During the same sequence it also raises start_i with different operands, to show that the running three-cycle sequence is left untouched.

// File: rtl/ixs_pkg.sv
package ixs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DEAD = 2'd1,
    ST_RD   = 2'd2,
    ST_WR   = 2'd3
  } ixs_state_e;
endpackage

// File: rtl/ixs_addr_calc.sv
module ixs_addr_calc #(
  parameter int ADDR_W = 16,
  parameter int LOW_W  = 8
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LOW_W-1:0]  index_i,
  output logic [ADDR_W-1:0] full_o,
  output logic [ADDR_W-1:0] partial_o,
  output logic              cross_o
);
  localparam int HI_W = ADDR_W - LOW_W;

  logic [LOW_W:0]  low_sum;
  logic [HI_W-1:0] hi_base;
  logic [HI_W-1:0] hi_inc;

  assign low_sum   = {1'b0, base_i[LOW_W-1:0]} + {1'b0, index_i};
  assign hi_base   = base_i[ADDR_W-1:LOW_W];
  assign hi_inc    = hi_base + HI_W'(1);  // wraps at top of space
  assign cross_o   = low_sum[LOW_W];
  assign partial_o = {hi_base, low_sum[LOW_W-1:0]};
  assign full_o    = {cross_o ? hi_inc : hi_base, low_sum[LOW_W-1:0]};
endmodule

// File: rtl/ixs_seq_fsm.sv
module ixs_seq_fsm
  import ixs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       cross_i,
  input  logic       store_i,
  input  logic       store_q_i,
  input  logic       legacy_q_i,
  output ixs_state_e state_o,
  output logic       dead_o,
  output logic       done_o,
  output logic       rnw_o
);
  ixs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = cross_i ? ST_DEAD : (store_i ? ST_RD : ST_RD);
      ST_DEAD: state_d = (store_q_i && !legacy_q_i) ? ST_WR : ST_RD;
      ST_RD:   state_d = store_q_i ? ST_WR : ST_IDLE;
      ST_WR:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign dead_o  = (state_q == ST_DEAD);
  assign rnw_o   = (state_q != ST_WR);
  assign done_o  = (state_q == ST_WR) || (state_q == ST_RD && !store_q_i);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5
  dead_is_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead_o |-> rnw_o);

  // R9
  dead_not_final_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead_o |=> !dead_o);
endmodule

// File: rtl/idx_bus_sequencer.sv
module idx_bus_sequencer
  import ixs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LOW_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LOW_W-1:0]  index_i,
  input  logic              store_i,
  input  logic              legacy_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rnw_o,
  output logic              dead_o,
  output logic              done_o
);
  localparam int HI_W = ADDR_W - LOW_W;

  ixs_state_e        state;
  logic              accept;
  logic [ADDR_W-1:0] base_q, pc_q;
  logic [LOW_W-1:0]  index_q;
  logic              store_q, legacy_q;

  logic [ADDR_W-1:0] full_now, partial_now, full_q, partial_q;
  logic              cross_now, cross_q;

  assign accept = start_i && (state == ST_IDLE);

  // live calc decides the first state, latched calc drives the bus
  ixs_addr_calc #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_calc_live (
    .base_i   (base_i),
    .index_i  (index_i),
    .full_o   (full_now),
    .partial_o(partial_now),
    .cross_o  (cross_now)
  );

  ixs_addr_calc #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_calc_held (
    .base_i   (base_q),
    .index_i  (index_q),
    .full_o   (full_q),
    .partial_o(partial_q),
    .cross_o  (cross_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      index_q  <= '0;
      pc_q     <= '0;
      store_q  <= 1'b0;
      legacy_q <= 1'b0;
    end else if (accept) begin
      base_q   <= base_i;
      index_q  <= index_i;
      pc_q     <= pc_i;
      store_q  <= store_i;
      legacy_q <= legacy_i;
    end
  end

  ixs_seq_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (accept),
    .cross_i   (cross_now),
    .store_i   (store_i),
    .store_q_i (store_q),
    .legacy_q_i(legacy_q),
    .state_o   (state),
    .dead_o    (dead_o),
    .done_o    (done_o),
    .rnw_o     (rnw_o)
  );

  always_comb begin
    unique case (state)
      ST_DEAD: addr_o = legacy_q ? partial_q : pc_q;
      ST_RD,
      ST_WR:   addr_o = full_q;
      default: addr_o = '0;
    endcase
  end

  logic unused_ok;
  assign unused_ok = ^{full_now, partial_now, cross_q};

  // R6
  write_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rnw_o |-> $past(rnw_o) && ($past(dead_o) || addr_o == $past(addr_o)));

  // R4
  legacy_partial_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dead_o && legacy_q) |=>
      addr_o[LOW_W-1:0] == $past(addr_o[LOW_W-1:0]) &&
      addr_o[ADDR_W-1:LOW_W] == $past(addr_o[ADDR_W-1:LOW_W]) + HI_W'(1));

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> (addr_o == '0 && rnw_o && !dead_o && !done_o));
endmodule

// File: tb/idx_bus_sequencer_bench.sv
module idx_bus_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] base = '0;
  logic [7:0]  index = '0;
  logic        store = 1'b0;
  logic        legacy = 1'b0;
  logic [15:0] pc = '0;
  logic [15:0] addr;
  logic        rnw, dead, done;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  idx_bus_sequencer u_idx_bus_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base),
    .index_i(index), .store_i(store), .legacy_i(legacy), .pc_i(pc),
    .addr_o(addr), .rnw_o(rnw), .dead_o(dead), .done_o(done)
  );

  task automatic expect_cycle(input string req, input logic [15:0] ea,
                              input logic er, input logic ed, input logic eo);
    checks++;
    if (addr !== ea || rnw !== er || dead !== ed || done !== eo) begin
      errors++;
      $display("FAIL %s: addr=%h rnw=%b dead=%b done=%b expected addr=%h rnw=%b dead=%b done=%b",
               req, addr, rnw, dead, done, ea, er, ed, eo);
    end
    @(negedge clk);
  endtask

  task automatic kick(input logic [15:0] b, input logic [7:0] i, input logic st,
                      input logic lg, input logic [15:0] p);
    @(negedge clk);
    base = b; index = i; store = st; legacy = lg; pc = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    base = 16'hDEAD; index = 8'h00; pc = 16'h0BAD; store = ~st; legacy = ~lg;
  endtask

  task automatic t_reset;
    expect_cycle("R1 reset", 16'h0000, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_read_nocross;
    kick(16'h1234, 8'h05, 1'b0, 1'b1, 16'h8000);
    expect_cycle("R2 read no cross", 16'h1239, 1'b1, 1'b0, 1'b1);
    expect_cycle("R1 idle after", 16'h0000, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_read_cross_legacy;
    kick(16'h12F0, 8'h20, 1'b0, 1'b1, 16'h8000);
    expect_cycle("R4 legacy dead partial", 16'h1210, 1'b1, 1'b1, 1'b0);
    expect_cycle("R3 read full after cross", 16'h1310, 1'b1, 1'b0, 1'b1);
    expect_cycle("R9 idle after done", 16'h0000, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_read_cross_revised;
    kick(16'h40FF, 8'h01, 1'b0, 1'b0, 16'hC123);
    expect_cycle("R5 revised dead pc", 16'hC123, 1'b1, 1'b1, 1'b0);
    expect_cycle("R3 read full revised", 16'h4100, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_store_nocross(input logic lg);
    kick(16'h2010, 8'h7F, 1'b1, lg, 16'h9999);
    expect_cycle("R6 store read first", 16'h208F, 1'b1, 1'b0, 1'b0);
    expect_cycle("R6 store write", 16'h208F, 1'b0, 1'b0, 1'b1);
    expect_cycle("R9 no extra done", 16'h0000, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_store_cross_revised;
    kick(16'h30C0, 8'h50, 1'b1, 1'b0, 16'hA5A5);
    expect_cycle("R7 pc read", 16'hA5A5, 1'b1, 1'b1, 1'b0);
    expect_cycle("R7 write full", 16'h3110, 1'b0, 1'b0, 1'b1);
    expect_cycle("R7 back idle", 16'h0000, 1'b1, 1'b0, 1'b0);
  endtask

  // legacy store crossing at top page, with a stray start mid-sequence
  task automatic t_store_cross_legacy_wrap;
    kick(16'hFF80, 8'h90, 1'b1, 1'b1, 16'h1111);
    expect_cycle("R8 partial read", 16'hFF10, 1'b1, 1'b1, 1'b0);
    base = 16'h0001; index = 8'h01; store = 1'b0; legacy = 1'b0; pc = 16'h7777;
    start = 1'b1;
    expect_cycle("R10 wrap full read", 16'h0010, 1'b1, 1'b0, 1'b0);
    start = 1'b0;
    expect_cycle("R11 write unchanged", 16'h0010, 1'b0, 1'b0, 1'b1);
    expect_cycle("R11 idle after ignored start", 16'h0000, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_read_wrap_revised;
    kick(16'hFFFF, 8'hFF, 1'b0, 1'b0, 16'h0042);
    expect_cycle("R5 dead pc at wrap", 16'h0042, 1'b1, 1'b1, 1'b0);
    expect_cycle("R10 read wrap", 16'h00FE, 1'b1, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_nocross();
    t_read_cross_legacy();
    t_read_cross_revised();
    t_store_nocross(1'b1);
    t_store_nocross(1'b0);
    t_store_cross_revised();
    t_store_cross_legacy_wrap();
    t_read_wrap_revised();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule